// File: doc/BRIEF.md
# Serial-Unlock Phantom Register Access

This block sits beside a byte-wide asynchronous memory bus and listens to the bus cycles that complete on it. It stays invisible at first, and every access goes to the memory. A 64-bit unlock key is sent one bit per write cycle on data line 0. Once the key has been matched, the block takes over the bus for the next 64 cycles. During those cycles it moves timekeeping register contents one bit at a time: a read cycle returns a bit and a write cycle supplies one.

The chip-enable, output-enable and write-enable strobes are brought into the system clock domain. A bus cycle is counted once, when its strobes go inactive. When the key is accepted, the block takes a snapshot of the timekeeper's eight 8-bit registers into a 64-bit shadow register. Transfer bits are read from and written into that shadow. If any bit was written, the whole shadow is handed back to the timekeeper in a single-cycle parallel load after the 64th transfer cycle. A bit in the timekeeper's own register contents decides whether an external active-low reset input may abort a transfer.

Top module: `phantom_access`

## Requirements
- R1: After reset, `mem_en` is 1, `dq0_oe` is 0 and `tk_load` is 0.
- R2: Before the key is matched, read and write cycles leave `mem_en` at 1, including the write cycles that carry key bits.
- R3: After any read cycle, 64 write cycles whose data bit 0 follows the key unlock the block, and `mem_en` falls to 0. The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, taken in that order with each byte least significant bit first.
- R4: A write whose bit differs from the expected key bit stops recognition. Later writes are ignored until a read cycle restarts it from key bit 0.
- R5: A read cycle in the middle of recognition resets the comparison to key bit 0.
- R6: During the transfer, the k-th cycle (k = 0..63) reads register k/8, bit k%8, of the snapshot taken at unlock. Bit index = 8·register + bit in `tk_rd_data`. While such a read is in progress, `dq0_oe` is 1 and `dq0_out` carries that bit.
- R7: Write cycles in the transfer replace shadow bit k. After the 64th cycle, if any write occurred, `tk_load` pulses for one clock, and `tk_wr_data` then holds the written bits with all other bits as snapshotted.
- R8: A transfer made of reads only ends without a `tk_load` pulse.
- R9: After the 64th transfer cycle, `mem_en` returns to 1 and recognition starts at key bit 0, with no read needed first.
- R10: While `tk_rd_data` bit 36 (register 4, bit 4) is 0, a low level on `ext_rst_n` aborts a transfer: `mem_en` returns to 1 and no load occurs. While that bit is 1, `ext_rst_n` has no effect.
- R11: A cycle is counted only while chip-enable is low together with output-enable or write-enable. Strobe activity with chip-enable high affects neither recognition nor transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Bus chip-enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output-enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write-enable, active low, asynchronous |
| bus_dq0_in | input | 1 | Data line 0 as driven by the bus master |
| ext_rst_n | input | 1 | External abort request, active low |
| tk_rd_data | input | 64 | Current timekeeper register contents |
| dq0_out | output | 1 | Bit returned on data line 0 in transfer reads |
| dq0_oe | output | 1 | Drive enable for data line 0 |
| mem_en | output | 1 | 1 when memory access is allowed |
| tk_wr_data | output | 64 | Register contents to load into the timekeeper |
| tk_load | output | 1 | One-clock parallel load strobe |

## Verification
The assertions assume that each bus cycle holds its strobes and data bit steady for several system clocks. Under that assumption a completion edge is never seen twice in a row, and the sampled bit is the one the master meant. They also assume `tk_rd_data` is stable while the reset-enable bit is consulted. The stimulus holds every strobe level for five clocks and leaves four idle clocks between cycles. It changes the timekeeper contents only between transfers. Random key-bit corruption, random read/write mixes and random register contents come from a seeded generator.

// File: rtl/phantom_pkg.sv
package phantom_pkg;
  localparam int KEY_LEN = 64;
  // byte 0 in the low bits, each byte sent bit 0 first
  localparam logic [KEY_LEN-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;
  // positions of the synchronised bus pins
  localparam int PIN_CE  = 0;
  localparam int PIN_OE  = 1;
  localparam int PIN_WE  = 2;
  localparam int PIN_DQ  = 3;
  localparam int PIN_XR  = 4;
  localparam int PIN_CNT = 5;
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 5'b10111;
endpackage

// File: rtl/phantom_bus_front.sv
module phantom_bus_front
  import phantom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic dq_in,
  input  logic xrst_n,
  output logic rd_ev,
  output logic wr_ev,
  output logic bit_q,
  output logic rd_active,
  output logic xrst_low
);
  logic [PIN_CNT-1:0] raw;
  logic [PIN_CNT-1:0] stage [SYNC_STAGES];
  logic [PIN_CNT-1:0] pins;
  logic act, act_q, cyc_wr;

  always_comb begin
    raw = '0;
    raw[PIN_CE] = ce_n;
    raw[PIN_OE] = oe_n;
    raw[PIN_WE] = we_n;
    raw[PIN_DQ] = dq_in;
    raw[PIN_XR] = xrst_n;
  end

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= PIN_IDLE;
    else     stage[0] <= raw;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= PIN_IDLE;
        else     stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign pins = stage[SYNC_STAGES-1];
  assign act  = !pins[PIN_CE] && (!pins[PIN_OE] || !pins[PIN_WE]);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cyc_wr <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      act_q  <= act;
      cyc_wr <= act && (cyc_wr || !pins[PIN_WE]);
      if (act) bit_q <= pins[PIN_DQ];
    end
  end

  assign rd_ev     = act_q && !act && !cyc_wr;
  assign wr_ev     = act_q && !act && cyc_wr;
  assign rd_active = act && pins[PIN_WE] && !pins[PIN_OE];
  assign xrst_low  = !pins[PIN_XR];

  // R11: a completed cycle produces a single event
  a_r11_rd_once: assert property (@(posedge clk) disable iff (rst) rd_ev |=> !rd_ev);
  a_r11_wr_once: assert property (@(posedge clk) disable iff (rst) wr_ev |=> !wr_ev);
endmodule

// File: rtl/phantom_key_match.sv
module phantom_key_match #(
  parameter int KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0] KEY = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rd_ev,
  input  logic wr_ev,
  input  logic bit_in,
  output logic unlock
);
  localparam int PW = $clog2(KEY_BITS);
  localparam logic [PW-1:0] LAST = PW'(KEY_BITS - 1);

  logic [PW-1:0] ptr;
  logic fail, hit;

  assign hit    = enable && wr_ev && !fail && (bit_in == KEY[ptr]);
  assign unlock = hit && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      fail <= 1'b0;
    end else if (enable) begin
      if (rd_ev) begin
        ptr  <= '0;
        fail <= 1'b0;
      end else if (wr_ev && !fail) begin
        if (hit) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        else     fail <= 1'b1;
      end
    end
  end

  // R3: the pointer only steps forward by one or returns to zero
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + 1'b1 || ptr == '0));
  // R4: a mismatch persists until a read
  a_r4_fail_hold: assert property (@(posedge clk) disable iff (rst)
    (fail && !rd_ev) |=> fail);
endmodule

// File: rtl/phantom_xfer.sv
module phantom_xfer #(
  parameter int REG_BITS   = 64,
  parameter int RST_EN_BIT = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                rd_ev,
  input  logic                wr_ev,
  input  logic                bit_in,
  input  logic                xrst_low,
  input  logic [REG_BITS-1:0] tk_rd_data,
  output logic                busy,
  output logic                cur_bit,
  output logic [REG_BITS-1:0] tk_wr_data,
  output logic                tk_load
);
  localparam int CW = $clog2(REG_BITS);
  localparam logic [CW-1:0] LAST = CW'(REG_BITS - 1);

  logic [REG_BITS-1:0] shadow;
  logic [CW-1:0]       cnt;
  logic                dirty, abort;

  assign abort = busy && xrst_low && !tk_rd_data[RST_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      dirty   <= 1'b0;
      shadow  <= '0;
      tk_load <= 1'b0;
    end else begin
      tk_load <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        dirty  <= 1'b0;
        shadow <= tk_rd_data;
      end else if (abort) begin
        busy  <= 1'b0;
        cnt   <= '0;
        dirty <= 1'b0;
      end else if (busy && (rd_ev || wr_ev)) begin
        if (wr_ev) shadow[cnt] <= bit_in;
        if (cnt == LAST) begin
          busy    <= 1'b0;
          cnt     <= '0;
          dirty   <= 1'b0;
          tk_load <= dirty || wr_ev;
        end else begin
          cnt   <= cnt + 1'b1;
          dirty <= dirty || wr_ev;
        end
      end
    end
  end

  assign cur_bit    = shadow[cnt];
  assign tk_wr_data = shadow;

  // R7: load strobe lasts one clock
  a_r7_load_single: assert property (@(posedge clk) disable iff (rst) tk_load |=> !tk_load);
  // R9: a finished or aborted transfer leaves the counter at zero
  a_r9_cnt_clear: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> cnt == '0);
  // R8: no load without a preceding transfer
  a_r8_load_after_busy: assert property (@(posedge clk) disable iff (rst) tk_load |-> $past(busy));
endmodule

// File: rtl/phantom_access.sv
module phantom_access
  import phantom_pkg::*;
#(
  parameter int REG_COUNT   = 8,
  parameter int REG_WIDTH   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_EN_BIT  = 36,
  parameter int KEY_BITS    = KEY_LEN,
  parameter logic [KEY_BITS-1:0] KEY = UNLOCK_KEY
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_ce_n,
  input  logic                           bus_oe_n,
  input  logic                           bus_we_n,
  input  logic                           bus_dq0_in,
  input  logic                           ext_rst_n,
  input  logic [REG_COUNT*REG_WIDTH-1:0] tk_rd_data,
  output logic                           dq0_out,
  output logic                           dq0_oe,
  output logic                           mem_en,
  output logic [REG_COUNT*REG_WIDTH-1:0] tk_wr_data,
  output logic                           tk_load
);
  localparam int REG_BITS = REG_COUNT * REG_WIDTH;

  logic rd_ev, wr_ev, bit_q, rd_active, xrst_low;
  logic unlock, busy, cur_bit;

  phantom_bus_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst),
    .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
    .dq_in(bus_dq0_in), .xrst_n(ext_rst_n),
    .rd_ev(rd_ev), .wr_ev(wr_ev), .bit_q(bit_q),
    .rd_active(rd_active), .xrst_low(xrst_low)
  );

  phantom_key_match #(.KEY_BITS(KEY_BITS), .KEY(KEY)) u_match (
    .clk(clk), .rst(rst), .enable(!busy),
    .rd_ev(rd_ev), .wr_ev(wr_ev), .bit_in(bit_q),
    .unlock(unlock)
  );

  phantom_xfer #(.REG_BITS(REG_BITS), .RST_EN_BIT(RST_EN_BIT)) u_xfer (
    .clk(clk), .rst(rst), .start(unlock),
    .rd_ev(rd_ev), .wr_ev(wr_ev), .bit_in(bit_q),
    .xrst_low(xrst_low), .tk_rd_data(tk_rd_data),
    .busy(busy), .cur_bit(cur_bit),
    .tk_wr_data(tk_wr_data), .tk_load(tk_load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq0_out <= 1'b0;
      dq0_oe  <= 1'b0;
    end else begin
      dq0_out <= cur_bit;
      dq0_oe  <= busy && rd_active;
    end
  end

  assign mem_en = !busy;

  // R6: the data line is driven only while memory was blocked
  a_r6_oe_blocked: assert property (@(posedge clk) disable iff (rst) dq0_oe |-> $past(!mem_en));
  // R2: memory is released again only after a cycle event or an abort request
  a_r2_release_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_en) |-> $past(rd_ev || wr_ev || xrst_low));
endmodule

// File: tb/phantom_access_test.sv
module phantom_access_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq = 1'b0, xr_n = 1'b1;
  logic [63:0] tk_rd = '0;
  logic dq0_out, dq0_oe, mem_en, tk_load;
  logic [63:0] tk_wr;

  int vectors = 0;
  int misses = 0;
  int loads = 0;
  logic [63:0] last_load = '0;
  logic [63:0] expv;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phantom_access uut (
    .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_dq0_in(dq), .ext_rst_n(xr_n), .tk_rd_data(tk_rd),
    .dq0_out(dq0_out), .dq0_oe(dq0_oe), .mem_en(mem_en),
    .tk_wr_data(tk_wr), .tk_load(tk_load)
  );

  always @(posedge clk) if (tk_load) begin
    loads <= loads + 1;
    last_load <= tk_wr;
  end

  function automatic bit key_bit(int i);
    logic [63:0] k;
    k = {8'h5C, 8'hA3, 8'h3A, 8'hC5, 8'h5C, 8'hA3, 8'h3A, 8'hC5};
    return k[i];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input bit b, input bit ce_on,
                     output bit rbit, output bit roe);
    @(negedge clk);
    ce_n = !ce_on; oe_n = wr; we_n = !wr; dq = b;
    repeat (5) @(negedge clk);
    rbit = dq0_out; roe = dq0_oe;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_bit(input bit b);
    bit x, y;
    cyc(1'b1, b, 1'b1, x, y);
  endtask

  task automatic rd_cyc();
    bit x, y;
    cyc(1'b0, 1'b0, 1'b1, x, y);
  endtask

  task automatic send_key(input int from, input int upto, input int flip);
    for (int i = from; i < upto; i++) wr_bit(key_bit(i) ^ (i == flip));
  endtask

  // finish a transfer with reads, checking each returned bit
  task automatic read_rest(input int from, input logic [63:0] snap, input string req);
    bit rb, ro;
    for (int k = from; k < 64; k++) begin
      cyc(1'b0, 1'b0, 1'b1, rb, ro);
      chk({req, " read bit"}, {62'd0, ro, rb}, {62'd0, 1'b1, snap[k]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    bit rb, ro, b;
    int nl;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1
    chk("R1 mem_en", {63'd0, mem_en}, 64'd1);
    chk("R1 dq0_oe", {63'd0, dq0_oe}, 64'd0);
    chk("R1 loads", 64'(loads), 64'd0);

    // R2: random pass-through traffic
    for (int i = 0; i < 6; i++) begin
      cyc(i[0], 1'($urandom), 1'b1, rb, ro);
      chk("R2 pass mem_en", {62'd0, mem_en, ro}, 64'd2);
    end

    // R3 / R2 / R6 / R7: unlock then random mix
    tk_rd = {$urandom, $urandom};
    tk_rd[36] = 1'b1;
    rd_cyc();
    send_key(0, 63, -1);
    chk("R2 key writes pass", {63'd0, mem_en}, 64'd1);
    send_key(63, 64, -1);
    chk("R3 unlocked", {63'd0, mem_en}, 64'd0);
    expv = tk_rd;
    tk_rd = ~tk_rd; tk_rd[36] = 1'b1; // snapshot must not follow later changes
    nl = loads;
    for (int k = 0; k < 64; k++) begin
      if ($urandom_range(1, 0) == 1 || k == 5) begin
        b = 1'($urandom);
        cyc(1'b1, b, 1'b1, rb, ro);
        expv[k] = b;
      end else begin
        cyc(1'b0, 1'b0, 1'b1, rb, ro);
        chk("R6 read bit", {62'd0, ro, rb}, {62'd0, 1'b1, expv[k]});
      end
    end
    chk("R9 released", {63'd0, mem_en}, 64'd1);
    chk("R7 load count", 64'(loads - nl), 64'd1);
    chk("R7 load data", last_load, expv);

    // R9: key again without read; R8: reads only
    tk_rd = {$urandom, $urandom}; tk_rd[36] = 1'b1;
    send_key(0, 64, -1);
    chk("R9 relock no read", {63'd0, mem_en}, 64'd0);
    nl = loads;
    read_rest(0, tk_rd, "R8");
    chk("R8 no load", 64'(loads - nl), 64'd0);
    chk("R9 mem back", {63'd0, mem_en}, 64'd1);

    // R4: a wrong bit blocks the rest
    rd_cyc();
    send_key(0, 64, 10 + int'($urandom_range(40, 0)));
    chk("R4 mismatch no unlock", {63'd0, mem_en}, 64'd1);
    send_key(0, 64, -1); // still ignored, no read
    chk("R4 ignored until read", {63'd0, mem_en}, 64'd1);
    rd_cyc();
    send_key(0, 64, -1);
    chk("R4 unlock after read", {63'd0, mem_en}, 64'd0);
    read_rest(0, tk_rd, "R4");

    // R5: read mid-sequence restarts
    rd_cyc();
    send_key(0, 20, -1);
    rd_cyc();
    send_key(20, 64, -1);
    chk("R5 restart no unlock", {63'd0, mem_en}, 64'd1);
    rd_cyc();
    send_key(0, 20, -1);
    rd_cyc();
    send_key(0, 64, -1);
    chk("R5 full after restart", {63'd0, mem_en}, 64'd0);
    read_rest(0, tk_rd, "R5");

    // R11: strobes without chip-enable are ignored
    rd_cyc();
    send_key(0, 32, -1);
    cyc(1'b0, 1'b0, 1'b0, rb, ro);
    cyc(1'b1, !key_bit(32), 1'b0, rb, ro);
    send_key(32, 64, -1);
    chk("R11 unlock kept", {63'd0, mem_en}, 64'd0);
    cyc(1'b1, 1'b0, 1'b0, rb, ro); // would be transfer cycle 0
    read_rest(0, tk_rd, "R11");
    chk("R11 transfer length", {63'd0, mem_en}, 64'd1);

    // R10: abort enabled (bit 36 = 0)
    tk_rd = {$urandom, $urandom}; tk_rd[36] = 1'b0;
    nl = loads;
    rd_cyc();
    send_key(0, 64, -1);
    for (int k = 0; k < 10; k++) wr_bit(1'($urandom));
    @(negedge clk); xr_n = 1'b0;
    repeat (4) @(negedge clk); xr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 abort releases", {63'd0, mem_en}, 64'd1);
    chk("R10 abort no load", 64'(loads - nl), 64'd0);

    // R10: abort disabled (bit 36 = 1)
    tk_rd = {$urandom, $urandom}; tk_rd[36] = 1'b1;
    expv = tk_rd;
    rd_cyc();
    send_key(0, 64, -1);
    for (int k = 0; k < 10; k++) begin
      b = 1'($urandom); wr_bit(b); expv[k] = b;
    end
    @(negedge clk); xr_n = 1'b0;
    repeat (4) @(negedge clk); xr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset ignored", {63'd0, mem_en}, 64'd0);
    for (int k = 10; k < 64; k++) begin
      b = 1'($urandom); wr_bit(b); expv[k] = b;
    end
    chk("R10 load after ignore", 64'(loads - nl), 64'd1);
    chk("R10 load data", last_load, expv);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule